// File: doc/BRIEF.md
# Floppy Controller Status Register Unit

This block supplies the two read-only status bytes of a PC-compatible floppy disk controller. These are the bytes at register offsets 0 (status A) and 1 (status B). The block watches the drive interface. The track-zero line, the serial read-data line and the serial write-data line come from the drive and are asynchronous, so each one passes through a synchronizer. The step, motor-enable-0, write-gate and drive-select-0 levels come from the controller's own clock domain, as do the DMA request and the interrupt line.

The serial data lines do not appear directly in a status byte. Each low-to-high (inactive) transition of one of those lines flips its own toggle bit. A rising step output sets a sticky bit. That bit stays set until the host decoder reports a read of the digital input register, or until a reset clears it. A hardware reset and a software reset clear different groups of bits. The host reads through a strobe and a 3-bit offset. An output-enable flag tells the bus logic whether the block drives the data lines. In PC/AT mode the block leaves status B undriven.

Top module: `fdc_status_regs`

## Requirements
- R1: Whenever status B (offset 1) is driven, bits 7 and 6 read 1 and bit 1 reads 0.
- R2: A read of offset 1 asserts `rd_oe` only when `ps2_mode` is 1 (PS/2 mode). In PC/AT mode (`ps2_mode` = 0) `rd_oe` stays low. Offset 0 is driven in both modes.
- R3: Status A has bit 4 = synchronized track-zero, bit 6 = DMA request and bit 7 = interrupt line, all active high. Bits 3..0 read 0.
- R4: Status B bit 3 inverts once for every low-to-high transition of `rdata_n`. The change is visible within 4 clock cycles of the transition.
- R5: Status B bit 4 inverts once for every low-to-high transition of `wdata_n`. The change is visible within 4 clock cycles of the transition.
- R6: Status A bit 5 is set by a rising edge of `step_out`. It stays set through any number of cycles until a cycle in which `dir_rd` is 1.
- R7: If a rising edge of `step_out` and a `dir_rd` pulse fall in the same cycle, status A bit 5 ends up set.
- R8: While `rst_n` is low, status B reads 0xC0 and status A bits 5 and 4 read 0, whatever the interface inputs are.
- R9: A one-cycle `soft_rst` clears status A bit 5 and status B bits 3 and 4.
- R10: `soft_rst` leaves status B bit 0 (motor enable 0) and bit 5 (drive select 0) unchanged.
- R11: Status B bit 0 follows `motor0_out`, bit 2 follows `wgate_out` and bit 5 follows `dsel0`, each one clock cycle after the input.
- R12: A read of any offset from 2 to 7 leaves `rd_oe` low and `rd_data` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| soft_rst | input | 1 | Software reset pulse, active high |
| ps2_mode | input | 1 | 1 = PS/2 mode, 0 = PC/AT mode |
| trk0_in | input | 1 | Track-zero from drive, asynchronous, active high |
| step_out | input | 1 | Step output level, active high |
| drq_in | input | 1 | DMA request pending |
| fint_in | input | 1 | Floppy interrupt line |
| motor0_out | input | 1 | Motor enable 0 output level |
| wgate_out | input | 1 | Write gate output level |
| dsel0 | input | 1 | Drive select 0 bit of the digital output register |
| rdata_n | input | 1 | Serial read data, asynchronous, active low |
| wdata_n | input | 1 | Serial write data, asynchronous, active low |
| dir_rd | input | 1 | One-cycle pulse: digital input register was read |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | 3 | Register offset of the read |
| rd_data | output | 8 | Read data, 0 when not driven |
| rd_oe | output | 1 | Block drives the data bus this cycle |

## Verification
The toggle bits are driven with one, two and three pulses on each serial line. An odd count leaves the bit set and an even count leaves it clear, so a missed edge or a doubled edge shows up. One pulse is always on the read-data line while the write-data line stays idle, which tells the two channels apart. The step latch is tested in three ways: held with no clear, cleared by a `dir_rd` pulse, and set in the same cycle as a clear, which separates the two possible priorities. Both resets are applied with every bit set and the motor and drive-select inputs held high. This shows which bits each reset clears and which ones it leaves alone.

// File: rtl/fdc_stat_pkg.sv
// Package: register offsets, bit positions and channel indices used across
// the floppy status register unit. Assumes a 3-bit register offset.
package fdc_stat_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] OFS_STAT_A = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT_B = 3'd1;

    // toggle channel indices
    localparam int TOG_RD  = 0;
    localparam int TOG_WR  = 1;
    localparam int N_TOG   = 2;

    // synchronized input vector layout
    localparam int SY_TRK  = 0;
    localparam int SY_RD   = 1;
    localparam int SY_WR   = 2;
    localparam int N_SYNC  = 3;

    // status B constant bits
    localparam logic [1:0] STB_RSVD_HI = 2'b11;
endpackage

// File: rtl/fdc_sync.sv
// Module: multi-bit, multi-stage synchronizer for asynchronous drive inputs.
// Assumes each bit is independent (no bus coherency needed). Reset value per
// bit is a parameter so active-low lines start at their idle level.
module fdc_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // shift the raw inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fdc_toggle_bank.sv
// Module: bank of toggle bits, one per active-low synchronized line. Each
// low-to-high (inactive) transition gives a one-cycle pulse that flips the
// channel's bit. Assumes lines are already synchronous to clk.
module fdc_toggle_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [N-1:0] line_n,
    output logic [N-1:0] tog,
    output logic [N-1:0] pulse
);
    for (genvar g = 0; g < N; g++) begin : g_chan
        logic prev;

        // remember last level for edge detection (idle level is high)
        always_ff @(posedge clk) begin
            if (!rst_n) prev <= 1'b1;
            else        prev <= line_n[g];
        end

        assign pulse[g] = line_n[g] & ~prev;

        // flip on each inactive edge; both resets clear
        always_ff @(posedge clk) begin
            if (!rst_n)        tog[g] <= 1'b0;
            else if (soft_clr) tog[g] <= 1'b0;
            else if (pulse[g]) tog[g] <= ~tog[g];
        end
    end
endmodule

// File: rtl/fdc_step_latch.sv
// Module: sticky step indicator. Sets on the rising edge of the step level,
// clears on a digital-input-register read pulse; set beats clear, resets
// beat set. Assumes step level is synchronous to clk.
module fdc_step_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic step_in,
    input  logic clr_pulse,
    output logic latched
);
    logic step_prev;
    logic step_rise;

    // remember previous step level
    always_ff @(posedge clk) begin
        if (!rst_n) step_prev <= 1'b0;
        else        step_prev <= step_in;
    end

    assign step_rise = step_in & ~step_prev;

    // sticky bit with reset > set > clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)         latched <= 1'b0;
        else if (soft_clr)  latched <= 1'b0;
        else if (step_rise) latched <= 1'b1;
        else if (clr_pulse) latched <= 1'b0;
    end
endmodule

// File: rtl/fdc_status_regs.sv
// Module: floppy controller status bytes A and B with host read port.
// Assumes: rst_n synchronous active low; soft_rst, dir_rd, rd_stb are
// synchronous to clk; trk0_in, rdata_n, wdata_n are asynchronous.
// rd_data is 0 whenever rd_oe is low (models an undriven bus).
module fdc_status_regs
    import fdc_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ps2_mode,
    input  logic              trk0_in,
    input  logic              step_out,
    input  logic              drq_in,
    input  logic              fint_in,
    input  logic              motor0_out,
    input  logic              wgate_out,
    input  logic              dsel0,
    input  logic              rdata_n,
    input  logic              wdata_n,
    input  logic              dir_rd,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    localparam logic [N_SYNC-1:0] SYNC_RST = 3'b110;

    logic [N_SYNC-1:0] sync_q;
    logic [N_TOG-1:0]  tog_q;
    logic [N_TOG-1:0]  tog_pulse;
    logic              step_q;
    logic              mot_q, wg_q, ds_q;
    logic [DATA_W-1:0] stat_a, stat_b;

    fdc_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(SYNC_RST)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({wdata_n, rdata_n, trk0_in}),
        .q    (sync_q)
    );

    fdc_toggle_bank #(
        .N(N_TOG)
    ) tog_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(soft_rst),
        .line_n  ({sync_q[SY_WR], sync_q[SY_RD]}),
        .tog     (tog_q),
        .pulse   (tog_pulse)
    );

    fdc_step_latch step_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_rst),
        .step_in  (step_out),
        .clr_pulse(dir_rd),
        .latched  (step_q)
    );

    // mirror of output levels; only hardware reset touches them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mot_q <= 1'b0;
            wg_q  <= 1'b0;
            ds_q  <= 1'b0;
        end else begin
            mot_q <= motor0_out;
            wg_q  <= wgate_out;
            ds_q  <= dsel0;
        end
    end

    // assemble the two status bytes
    always_comb begin
        stat_a = {fint_in, drq_in, step_q, sync_q[SY_TRK], 4'b0000};
        stat_b = {STB_RSVD_HI, ds_q, tog_q[TOG_WR], tog_q[TOG_RD],
                  wg_q, 1'b0, mot_q};
    end

    // host read decode with mode-dependent drive of status B
    always_comb begin
        rd_oe   = 1'b0;
        rd_data = '0;
        if (rd_stb) begin
            if (rd_addr == OFS_STAT_A) begin
                rd_oe   = 1'b1;
                rd_data = stat_a;
            end else if (rd_addr == OFS_STAT_B && ps2_mode) begin
                rd_oe   = 1'b1;
                rd_data = stat_b;
            end
        end
    end
endmodule

// File: rtl/fdc_status_regs_chk.sv
// Checker for fdc_status_regs, attached by bind. Observes ports and the
// state bits held in the sub-blocks.
module fdc_status_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       ps2_mode,
    input logic       step_out,
    input logic       dir_rd,
    input logic       rd_stb,
    input logic [2:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       rd_oe,
    input logic       step_q,
    input logic [1:0] tog_q,
    input logic [1:0] tog_pulse
);
    a_r1_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && rd_addr == 3'd1) |-> (rd_data[7:6] == 2'b11 && !rd_data[1]));

    a_r2_at_mode_float: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == 3'd1 && !ps2_mode) |-> !rd_oe);

    a_r2_sta_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == 3'd0) |-> rd_oe);

    a_r12_unused_offsets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > 3'd1) |-> (!rd_oe && rd_data == 8'h00));

    a_r4_rd_toggle_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_q[0]) |-> ($past(tog_pulse[0]) || $past(soft_rst)));

    a_r5_wr_toggle_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_q[1]) |-> ($past(tog_pulse[1]) || $past(soft_rst)));

    a_r6_step_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(step_out) && !soft_rst) |=> step_q);

    a_r6_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q && !dir_rd && !soft_rst) |=> step_q);

    a_r6_step_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rd && !step_out) |=> !step_q);

    a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!step_q && tog_q == 2'b00));

    a_r8_hw_clear: assert property (@(posedge clk)
        !rst_n |=> (!step_q && tog_q == 2'b00));
endmodule

bind fdc_status_regs fdc_status_regs_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .ps2_mode (ps2_mode),
    .step_out (step_out),
    .dir_rd   (dir_rd),
    .rd_stb   (rd_stb),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_oe    (rd_oe),
    .step_q   (step_q),
    .tog_q    (tog_q),
    .tog_pulse(tog_pulse)
);

// File: tb/fdc_status_regs_tb_top.sv
// Directed bench for fdc_status_regs: one task per scenario, each checking
// its own results through the host read port.
module fdc_status_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       ps2_mode = 1'b1;
    logic       trk0_in = 1'b0;
    logic       step_out = 1'b0;
    logic       drq_in = 1'b0;
    logic       fint_in = 1'b0;
    logic       motor0_out = 1'b0;
    logic       wgate_out = 1'b0;
    logic       dsel0 = 1'b0;
    logic       rdata_n = 1'b1;
    logic       wdata_n = 1'b1;
    logic       dir_rd = 1'b0;
    logic       rd_stb = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       rd_oe;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    fdc_status_regs dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ps2_mode(ps2_mode),
        .trk0_in(trk0_in), .step_out(step_out), .drq_in(drq_in),
        .fint_in(fint_in), .motor0_out(motor0_out), .wgate_out(wgate_out),
        .dsel0(dsel0), .rdata_n(rdata_n), .wdata_n(wdata_n), .dir_rd(dir_rd),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // read one offset; returns {oe, data}
    task automatic rd(input logic [2:0] a, output logic [8:0] r);
        @(negedge clk);
        rd_stb  = 1'b1;
        rd_addr = a;
        #2;
        r = {rd_oe, rd_data};
        rd_stb  = 1'b0;
        rd_addr = 3'd0;
    endtask

    task automatic pulse_line(input bit wr_line);
        @(negedge clk);
        if (wr_line) wdata_n = 1'b0; else rdata_n = 1'b0;
        cyc(2);
        if (wr_line) wdata_n = 1'b1; else rdata_n = 1'b1;
        cyc(4);
    endtask

    task automatic t_reset_state;
        logic [8:0] r;
        motor0_out = 1'b1; dsel0 = 1'b1; trk0_in = 1'b1;
        cyc(3);
        rd(3'd1, r); check("R8 reset stat B", r, 9'h1C0);
        rd(3'd0, r); check("R8 reset stat A", r, 9'h100);
        @(negedge clk);
        rst_n = 1'b1;
        motor0_out = 1'b0; dsel0 = 1'b0; trk0_in = 1'b0;
        cyc(4);
    endtask

    task automatic t_mirror;
        logic [8:0] r;
        @(negedge clk);
        motor0_out = 1'b1; wgate_out = 1'b1; dsel0 = 1'b1;
        rd(3'd1, r); check("R11 mirror after one edge", r, 9'h1E5);
        rd(3'd1, r); check("R1 reserved bits with all set", {1'b0, r[7:6], 5'b0, r[1]}, 9'h0C0);
        @(negedge clk);
        motor0_out = 1'b0; wgate_out = 1'b0; dsel0 = 1'b0;
        rd(3'd1, r); check("R11 mirror clear", r, 9'h1C0);
    endtask

    task automatic t_stat_a;
        logic [8:0] r;
        @(negedge clk);
        trk0_in = 1'b1; drq_in = 1'b1; fint_in = 1'b1;
        cyc(3);
        rd(3'd0, r); check("R3 stat A all set", r, 9'h1D0);
        @(negedge clk);
        trk0_in = 1'b0; drq_in = 1'b0;
        cyc(3);
        rd(3'd0, r); check("R3 stat A interrupt only", r, 9'h180);
        fint_in = 1'b0;
    endtask

    task automatic t_toggles;
        logic [8:0] r;
        pulse_line(1'b0);
        rd(3'd1, r); check("R4 read toggle one edge", r, 9'h1C8);
        pulse_line(1'b0);
        rd(3'd1, r); check("R4 read toggle two edges", r, 9'h1C0);
        pulse_line(1'b1);
        rd(3'd1, r); check("R5 write toggle one edge", r, 9'h1D0);
        pulse_line(1'b1);
        pulse_line(1'b1);
        rd(3'd1, r); check("R5 write toggle three edges", r, 9'h1D0);
        pulse_line(1'b1);
        rd(3'd1, r); check("R5 write toggle four edges", r, 9'h1C0);
    endtask

    task automatic t_step;
        logic [8:0] r;
        @(negedge clk); step_out = 1'b1;
        cyc(2); step_out = 1'b0;
        cyc(5);
        rd(3'd0, r); check("R6 step latched and held", r, 9'h120);
        @(negedge clk); dir_rd = 1'b1;
        @(negedge clk); dir_rd = 1'b0;
        rd(3'd0, r); check("R6 step cleared by dir read", r, 9'h100);
        @(negedge clk); step_out = 1'b1; dir_rd = 1'b1;
        @(negedge clk); dir_rd = 1'b0;
        rd(3'd0, r); check("R7 set beats clear", r, 9'h120);
        step_out = 1'b0;
        cyc(2);
    endtask

    task automatic t_soft_reset;
        logic [8:0] r;
        motor0_out = 1'b1; dsel0 = 1'b1;
        pulse_line(1'b0);
        pulse_line(1'b1);
        rd(3'd1, r); check("R9 pre soft reset stat B", r, 9'h1F9);
        rd(3'd0, r); check("R9 pre soft reset stat A", r, 9'h120);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        rd(3'd1, r); check("R9 R10 soft reset stat B", r, 9'h1E1);
        rd(3'd0, r); check("R9 soft reset clears step", r, 9'h100);
    endtask

    task automatic t_hw_reset;
        logic [8:0] r;
        pulse_line(1'b0);
        @(negedge clk); step_out = 1'b1;
        @(negedge clk); step_out = 1'b0;
        trk0_in = 1'b1;
        cyc(3);
        rd(3'd1, r); check("R8 pre hw reset stat B", r, 9'h1E9);
        @(negedge clk); rst_n = 1'b0;
        cyc(2);
        rd(3'd1, r); check("R8 hw reset stat B", r, 9'h1C0);
        rd(3'd0, r); check("R8 hw reset stat A", r, 9'h100);
        @(negedge clk); rst_n = 1'b1;
        trk0_in = 1'b0;
        cyc(2);
        rd(3'd1, r); check("R11 mirror resumes after reset", r, 9'h1E1);
        motor0_out = 1'b0; dsel0 = 1'b0;
        cyc(4);
    endtask

    task automatic t_modes;
        logic [8:0] r;
        ps2_mode = 1'b0;
        rd(3'd1, r); check("R2 AT mode stat B undriven", r, 9'h000);
        rd(3'd0, r); check("R2 AT mode stat A driven", r, 9'h100);
        ps2_mode = 1'b1;
        rd(3'd1, r); check("R2 PS2 mode stat B driven", r, 9'h1C0);
        for (int a = 2; a < 8; a++) begin
            rd(3'(a), r); check("R12 unused offset", r, 9'h000);
        end
    endtask

    initial begin
        t_reset_state();
        t_mirror();
        t_stat_a();
        t_toggles();
        t_step();
        t_soft_reset();
        t_hw_reset();
        t_modes();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule